// File: doc/BRIEF.md
# Multichannel Converter Result and Interrupt Logic

This block is the digital back end of an eight-input analog-to-digital converter. The converter is outside the block. It reports each finished conversion as a single-cycle strobe that carries a 3-bit channel number and a 10-bit sample. The block keeps one result register per channel and one global result register that always holds the latest sample. Each register carries a done flag and an overrun flag, and both sets of flags are mirrored into a status word. A single interrupt line is raised from the done flags, gated by an enable mask.

The block also decides which channel is converted next. In burst mode it walks the channels picked by the select mask in ascending order and wraps back to the lowest selected channel, issuing one request per finished conversion. In burst mode the accuracy code trades clocks per conversion against result bits. Outside burst mode a request is issued only when software writes the start-now code. Software reaches everything through a plain register port: a write strobe, a read strobe, a word address, write data and combinational read data. A read that clears a flag takes effect at the clock edge that ends the read cycle.

The request sequencer has three states. SEQ_IDLE goes to SEQ_ISSUE when the select mask is non-zero and either burst is on or the start code equals 1. SEQ_ISSUE always goes to SEQ_WAIT after one cycle, and conv_req is high only in SEQ_ISSUE. SEQ_WAIT stays until a completion strobe arrives. It then goes back to SEQ_ISSUE when burst is on and the mask is non-zero, and otherwise returns to SEQ_IDLE.

Top module: `adc_result_ctrl`

## Requirements
- R1: After reset the following hold. Control (address 0) reads 0. Interrupt enable (address 2) reads 0x100. Status (address 3), the global result (address 1) and all channel results (addresses 8 to 15) read 0. irq and conv_req are 0.
- R2: In the cycle after a completion strobe, two registers show the sample in bits 15:6 and have done (bit 31) set. The first is the result register of that channel, at address 8 plus the channel number. The second is the global result, which also holds the channel number in bits 26:24.
- R3: The global done and overrun flags clear on a read of address 1 and on any write to address 0. A completion strobe in the same cycle takes precedence and leaves done set.
- R4: A read of a channel result register clears the done and overrun flags of that channel only.
- R5: A sample captured in burst mode sets the overrun flag (bit 30) of a register whose done flag was still set. A sample captured with burst off leaves overrun at 0.
- R6: Status (address 3) holds the eight channel done flags in bits 7:0, the eight channel overrun flags in bits 15:8 and the interrupt flag in bit 16.
- R7: irq is 1 when any channel done flag has its enable bit set in interrupt enable bits 7:0, or when global done is set and enable bit 8 is 1.
- R8: With burst (control bit 16) at 0, writing start code 1 to control bits 26:24 with a non-zero select mask (bits 7:0) has three effects. One conv_req pulse is issued for the lowest selected channel. The start field then reads back 0. No further request follows. Start codes other than 1 issue nothing.
- R9: With burst at 1, requests follow the selected channels in ascending order and wrap to the lowest selected one. A new request is issued in the cycle after each completion. Requests stop once burst is off or the mask is empty.
- R10: In burst mode the accuracy code c in control bits 19:17 drives conv_clocks to 11 - c, and the sample is stored shifted right by c. With burst off, conv_clocks is 11 and all 10 bits are stored.
- R11: Control reads back the select mask (bits 7:0), burst (bit 16), accuracy (bits 19:17), start (bits 26:24) and edge select (bit 27). All other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags at the clock edge) |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| conv_done | input | 1 | Conversion-complete strobe |
| conv_chan | input | 3 | Channel of the finished conversion |
| conv_value | input | 10 | Raw sample |
| conv_req | output | 1 | One-cycle conversion request |
| conv_req_chan | output | 3 | Channel to convert |
| conv_clocks | output | 4 | Clocks per conversion for the request |
| irq | output | 1 | Interrupt |

## Verification
The bench uses the default parameters: eight channels, 10-bit samples and a 4-bit word address. With these values every channel address, every status bit and all eight accuracy codes lie within a short run. The converter is modelled as answering each request three cycles later. That latency lets burst scans complete several rounds, so unread samples are overwritten, and it leaves room to stop a scan while a conversion is in flight.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;

    localparam int NUM_CH = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    // control word field positions (decoded by software)
    localparam int CTRL_SEL_LSB   = 0;
    localparam int CTRL_BURST_BIT = 16;
    localparam int CTRL_ACC_LSB   = 17;
    localparam int CTRL_START_LSB = 24;
    localparam int CTRL_EDGE_BIT  = 27;

    // result word field positions
    localparam int RES_VAL_LSB  = 6;
    localparam int RES_CHAN_LSB = 24;
    localparam int RES_OVR_BIT  = 30;
    localparam int RES_DONE_BIT = 31;

    // status word field positions
    localparam int STAT_OVR_LSB = 8;
    localparam int STAT_IRQ_BIT = 16;

    localparam logic [2:0] START_NOW = 3'd1;

    // register word addresses
    localparam int REG_CTRL  = 0;
    localparam int REG_GRES  = 1;
    localparam int REG_INTEN = 2;
    localparam int REG_STAT  = 3;

    typedef struct packed {
        logic              edge_sel;
        logic [2:0]        start;
        logic [2:0]        acc;
        logic              burst;
        logic [NUM_CH-1:0] sel;
    } ctrl_t;

endpackage

// File: rtl/adc_chan_scan.sv
module adc_chan_scan #(
    parameter int N_CHAN = 8
) (
    input  logic [N_CHAN-1:0]         sel_i,
    input  logic [$clog2(N_CHAN)-1:0] prev_i,
    output logic [$clog2(N_CHAN)-1:0] next_o,
    output logic                      any_o
);
    localparam int CH_W = $clog2(N_CHAN);

    logic [N_CHAN-1:0] above;
    logic [N_CHAN-1:0] pool;

    assign any_o = |sel_i;

    // lowest selected channel above prev, else lowest selected overall
    always_comb begin
        for (int i = 0; i < N_CHAN; i++) begin
            above[i] = sel_i[i] && (i > int'(prev_i));
        end
        pool   = (|above) ? above : sel_i;
        next_o = '0;
        for (int i = N_CHAN - 1; i >= 0; i--) begin
            if (pool[i]) next_o = CH_W'(i);
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_res_pkg::*;
#(
    parameter int N_CHAN = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      burst_i,
    input  logic [N_CHAN-1:0]         sel_i,
    input  logic [2:0]                start_i,
    input  logic                      conv_done_i,
    output logic                      conv_req_o,
    output logic [$clog2(N_CHAN)-1:0] req_chan_o,
    output logic                      start_clr_o
);
    localparam int CH_W = $clog2(N_CHAN);

    seq_state_e      state_q, state_d;
    logic [CH_W-1:0] cur_q;
    logic [CH_W-1:0] scan_prev, scan_next;
    logic            any_sel;

    assign scan_prev = (state_q == SEQ_IDLE) ? CH_W'(N_CHAN - 1) : cur_q;

    adc_chan_scan #(.N_CHAN(N_CHAN)) u_scan (
        .sel_i  (sel_i),
        .prev_i (scan_prev),
        .next_o (scan_next),
        .any_o  (any_sel)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (any_sel && (burst_i || start_i == START_NOW)) state_d = SEQ_ISSUE;
            SEQ_ISSUE: state_d = SEQ_WAIT;
            SEQ_WAIT:  if (conv_done_i) state_d = (burst_i && any_sel) ? SEQ_ISSUE : SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == SEQ_ISSUE && state_q != SEQ_ISSUE) cur_q <= scan_next;
        end
    end

    // outputs
    always_comb begin
        conv_req_o  = (state_q == SEQ_ISSUE);
        req_chan_o  = cur_q;
        start_clr_o = (state_q == SEQ_IDLE) && (state_d == SEQ_ISSUE) && !burst_i;
    end

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int N_CHAN = 8,
    parameter int RES_W  = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap_en_i,
    input  logic [$clog2(N_CHAN)-1:0]    cap_chan_i,
    input  logic [RES_W-1:0]             cap_val_i,
    input  logic                         burst_i,
    input  logic                         rd_en_i,
    input  logic [$clog2(N_CHAN)-1:0]    rd_chan_i,
    output logic [N_CHAN-1:0][RES_W-1:0] val_o,
    output logic [N_CHAN-1:0]            done_o,
    output logic [N_CHAN-1:0]            ovr_o
);
    localparam int CH_W = $clog2(N_CHAN);

    for (genvar g = 0; g < N_CHAN; g++) begin : g_ch
        logic             hit, clr;
        logic [RES_W-1:0] val_q;
        logic             done_q, ovr_q;

        assign hit = cap_en_i && (cap_chan_i == CH_W'(g));
        assign clr = rd_en_i && (rd_chan_i == CH_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q  <= '0;
                done_q <= 1'b0;
                ovr_q  <= 1'b0;
            end else if (hit) begin
                val_q  <= cap_val_i;
                done_q <= 1'b1;
                ovr_q  <= burst_i && done_q && !clr;
            end else if (clr) begin
                done_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
        end

        assign val_o[g]  = val_q;
        assign done_o[g] = done_q;
        assign ovr_o[g]  = ovr_q;
    end

endmodule

// File: rtl/adc_result_ctrl.sv
module adc_result_ctrl
    import adc_res_pkg::*;
#(
    parameter int N_CHAN = NUM_CH,
    parameter int RES_W  = 10,
    parameter int ADDR_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    input  logic                        conv_done,
    input  logic [$clog2(N_CHAN)-1:0]   conv_chan,
    input  logic [RES_W-1:0]            conv_value,
    output logic                        conv_req,
    output logic [$clog2(N_CHAN)-1:0]   conv_req_chan,
    output logic [$clog2(RES_W+2)-1:0]  conv_clocks,
    output logic                        irq
);
    localparam int CH_W      = $clog2(N_CHAN);
    localparam int CLK_W     = $clog2(RES_W + 2);
    localparam int FULL_CLKS = RES_W + 1;

    ctrl_t                      ctrl_q;
    logic [N_CHAN:0]            inten_q;
    logic [RES_W-1:0]           g_val_q;
    logic [CH_W-1:0]            g_chan_q;
    logic                       g_done_q, g_ovr_q;
    logic [N_CHAN-1:0][RES_W-1:0] ch_val;
    logic [N_CHAN-1:0]          ch_done, ch_ovr;
    logic                       wr_ctrl, wr_inten, rd_gres, g_clr, rd_chan_en;
    logic                       start_clr;
    logic [RES_W-1:0]           cap_val;
    logic                       unused_wdata;

    assign wr_ctrl    = reg_wr && (reg_addr == ADDR_W'(REG_CTRL));
    assign wr_inten   = reg_wr && (reg_addr == ADDR_W'(REG_INTEN));
    assign rd_gres    = reg_rd && (reg_addr == ADDR_W'(REG_GRES));
    assign g_clr      = rd_gres || wr_ctrl;
    assign rd_chan_en = reg_rd && reg_addr[ADDR_W-1];
    assign cap_val    = ctrl_q.burst ? (conv_value >> ctrl_q.acc) : conv_value;
    assign unused_wdata = ^{reg_wdata[31:28], reg_wdata[23:20], reg_wdata[15:9]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            inten_q <= {1'b1, {N_CHAN{1'b0}}};
        end else begin
            if (wr_ctrl) begin
                ctrl_q.sel      <= reg_wdata[CTRL_SEL_LSB +: N_CHAN];
                ctrl_q.burst    <= reg_wdata[CTRL_BURST_BIT];
                ctrl_q.acc      <= reg_wdata[CTRL_ACC_LSB +: 3];
                ctrl_q.start    <= reg_wdata[CTRL_START_LSB +: 3];
                ctrl_q.edge_sel <= reg_wdata[CTRL_EDGE_BIT];
            end else if (start_clr) begin
                ctrl_q.start <= '0;
            end
            if (wr_inten) inten_q <= reg_wdata[N_CHAN:0];
        end
    end

    // global result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_val_q  <= '0;
            g_chan_q <= '0;
            g_done_q <= 1'b0;
            g_ovr_q  <= 1'b0;
        end else if (conv_done) begin
            g_val_q  <= cap_val;
            g_chan_q <= conv_chan;
            g_done_q <= 1'b1;
            g_ovr_q  <= ctrl_q.burst && g_done_q && !g_clr;
        end else if (g_clr) begin
            g_done_q <= 1'b0;
            g_ovr_q  <= 1'b0;
        end
    end

    adc_result_bank #(.N_CHAN(N_CHAN), .RES_W(RES_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en_i   (conv_done),
        .cap_chan_i (conv_chan),
        .cap_val_i  (cap_val),
        .burst_i    (ctrl_q.burst),
        .rd_en_i    (rd_chan_en),
        .rd_chan_i  (reg_addr[CH_W-1:0]),
        .val_o      (ch_val),
        .done_o     (ch_done),
        .ovr_o      (ch_ovr)
    );

    adc_seq_fsm #(.N_CHAN(N_CHAN)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_i     (ctrl_q.burst),
        .sel_i       (ctrl_q.sel),
        .start_i     (ctrl_q.start),
        .conv_done_i (conv_done),
        .conv_req_o  (conv_req),
        .req_chan_o  (conv_req_chan),
        .start_clr_o (start_clr)
    );

    assign conv_clocks = ctrl_q.burst ? CLK_W'(FULL_CLKS - int'(ctrl_q.acc)) : CLK_W'(FULL_CLKS);
    assign irq = (|(ch_done & inten_q[N_CHAN-1:0])) || (inten_q[N_CHAN] && g_done_q);

    function automatic logic [31:0] pack_res(input logic [RES_W-1:0] v, input logic o,
                                             input logic d, input logic [CH_W-1:0] c);
        logic [31:0] r;
        r = '0;
        r[RES_VAL_LSB +: RES_W] = v;
        r[RES_CHAN_LSB +: CH_W] = c;
        r[RES_OVR_BIT]          = o;
        r[RES_DONE_BIT]         = d;
        return r;
    endfunction

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[ADDR_W-1]) begin
            reg_rdata = pack_res(ch_val[reg_addr[CH_W-1:0]], ch_ovr[reg_addr[CH_W-1:0]],
                                 ch_done[reg_addr[CH_W-1:0]], '0);
        end else if (reg_addr == ADDR_W'(REG_CTRL)) begin
            reg_rdata[CTRL_SEL_LSB +: N_CHAN] = ctrl_q.sel;
            reg_rdata[CTRL_BURST_BIT]         = ctrl_q.burst;
            reg_rdata[CTRL_ACC_LSB +: 3]      = ctrl_q.acc;
            reg_rdata[CTRL_START_LSB +: 3]    = ctrl_q.start;
            reg_rdata[CTRL_EDGE_BIT]          = ctrl_q.edge_sel;
        end else if (reg_addr == ADDR_W'(REG_GRES)) begin
            reg_rdata = pack_res(g_val_q, g_ovr_q, g_done_q, g_chan_q);
        end else if (reg_addr == ADDR_W'(REG_INTEN)) begin
            reg_rdata[N_CHAN:0] = inten_q;
        end else if (reg_addr == ADDR_W'(REG_STAT)) begin
            reg_rdata[N_CHAN-1:0]              = ch_done;
            reg_rdata[STAT_OVR_LSB +: N_CHAN]  = ch_ovr;
            reg_rdata[STAT_IRQ_BIT]            = irq;
        end
    end

endmodule

// File: rtl/adc_result_ctrl_chk.sv
module adc_result_ctrl_chk #(
    parameter int N_CHAN = 8,
    parameter int RES_W  = 10,
    parameter int ADDR_W = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic                       reg_rd,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic                       conv_done,
    input logic                       conv_req,
    input logic [$clog2(N_CHAN)-1:0]  conv_req_chan,
    input logic [$clog2(RES_W+2)-1:0] conv_clocks,
    input logic                       irq,
    input logic [N_CHAN-1:0]          sel,
    input logic                       burst,
    input logic [N_CHAN:0]            inten,
    input logic                       g_done,
    input logic                       g_ovr
);
    logic [N_CHAN-1:0] sel_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) sel_prev <= '0;
        else        sel_prev <= sel;
    end

    a_r8_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    a_r2_capture_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> g_done);

    a_r3_read_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(1) && !conv_done) |=> !g_done);

    a_r3_ctrl_write_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(0) && !conv_done) |=> !g_done);

    a_r5_no_overrun_without_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !burst) |=> !g_ovr);

    a_r7_global_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (inten[N_CHAN] && g_done) |-> irq);

    a_r9_req_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> sel_prev[conv_req_chan]);

    a_r10_clock_range: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (int'(conv_clocks) >= RES_W + 1 - 7 && int'(conv_clocks) <= RES_W + 1));

endmodule

bind adc_result_ctrl adc_result_ctrl_chk #(
    .N_CHAN (N_CHAN),
    .RES_W  (RES_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .conv_done     (conv_done),
    .conv_req      (conv_req),
    .conv_req_chan (conv_req_chan),
    .conv_clocks   (conv_clocks),
    .irq           (irq),
    .sel           (ctrl_q.sel),
    .burst         (ctrl_q.burst),
    .inten         (inten_q),
    .g_done        (g_done_q),
    .g_ovr         (g_ovr_q)
);

// File: tb/sim_adc_result_ctrl.sv
module sim_adc_result_ctrl;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        conv_done = 1'b0;
    logic [2:0]  conv_chan = '0;
    logic [9:0]  conv_value = '0;
    logic        conv_req;
    logic [2:0]  conv_req_chan;
    logic [3:0]  conv_clocks;
    logic        irq;

    always #5 clk = ~clk;

    adc_result_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_done(conv_done),
        .conv_chan(conv_chan), .conv_value(conv_value), .conv_req(conv_req),
        .conv_req_chan(conv_req_chan), .conv_clocks(conv_clocks), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;

    // ---------------- behavioural reference model ----------------
    int m_val[8], m_done[8], m_ovr[8];
    int g_val, g_ch, g_done, g_ovr;
    int m_sel, m_burst, m_acc, m_start, m_edge, m_inten, m_phase, m_cur;

    function automatic int next_after(int sel, int cur);
        for (int k = 1; k <= 8; k++) begin
            if (((sel >> ((cur + k) % 8)) & 1) == 1) return (cur + k) % 8;
        end
        return 0;
    endfunction

    always @(posedge clk) begin : model
        int o_sel, o_burst, o_acc, o_start, a, v, c;
        bit clr_start;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_done[i] = 0; m_ovr[i] = 0; end
            g_val = 0; g_ch = 0; g_done = 0; g_ovr = 0;
            m_sel = 0; m_burst = 0; m_acc = 0; m_start = 0; m_edge = 0;
            m_inten = 256; m_phase = 0; m_cur = 0;
        end else begin
            o_sel = m_sel; o_burst = m_burst; o_acc = m_acc; o_start = m_start;
            a = int'(reg_addr);
            clr_start = 0;
            if ((reg_rd && a == 1) || (reg_wr && a == 0)) begin g_done = 0; g_ovr = 0; end
            if (reg_rd && a >= 8) begin m_done[a-8] = 0; m_ovr[a-8] = 0; end
            if (conv_done) begin
                c = int'(conv_chan);
                v = (o_burst != 0) ? (int'(conv_value) >> o_acc) : int'(conv_value);
                m_ovr[c] = (o_burst != 0 && m_done[c] != 0) ? 1 : 0;
                m_done[c] = 1; m_val[c] = v;
                g_ovr = (o_burst != 0 && g_done != 0) ? 1 : 0;
                g_done = 1; g_val = v; g_ch = c;
            end
            case (m_phase)
                0: if (o_sel != 0 && (o_burst != 0 || o_start == 1)) begin
                       m_phase = 1; m_cur = next_after(o_sel, 7);
                       if (o_burst == 0) clr_start = 1;
                   end
                1: m_phase = 2;
                default: if (conv_done) begin
                       if (o_burst != 0 && o_sel != 0) begin
                           m_phase = 1; m_cur = next_after(o_sel, m_cur);
                       end else m_phase = 0;
                   end
            endcase
            if (reg_wr && a == 0) begin
                m_sel = int'(reg_wdata[7:0]); m_burst = int'(reg_wdata[16]);
                m_acc = int'(reg_wdata[19:17]); m_start = int'(reg_wdata[26:24]);
                m_edge = int'(reg_wdata[27]);
            end else if (clr_start) m_start = 0;
            if (reg_wr && a == 2) m_inten = int'(reg_wdata[8:0]);
        end
    end

    function automatic logic [31:0] m_irq();
        for (int i = 0; i < 8; i++) if (m_done[i] != 0 && ((m_inten >> i) & 1) == 1) return 1;
        return ((m_inten >> 8) & 1) == 1 && g_done != 0;
    endfunction

    function automatic logic [31:0] exp_rd(int a);
        logic [31:0] r;
        r = '0;
        if (a == 0) r = 32'(m_sel) | 32'(m_burst) << 16 | 32'(m_acc) << 17 | 32'(m_start) << 24 | 32'(m_edge) << 27;
        else if (a == 1) r = 32'(g_val) << 6 | 32'(g_ch) << 24 | 32'(g_ovr) << 30 | 32'(g_done) << 31;
        else if (a == 2) r = 32'(m_inten);
        else if (a == 3) begin
            for (int i = 0; i < 8; i++) r = r | 32'(m_done[i]) << i | 32'(m_ovr[i]) << (i + 8);
            r = r | m_irq() << 16;
        end else if (a >= 8) r = 32'(m_val[a-8]) << 6 | 32'(m_ovr[a-8]) << 30 | 32'(m_done[a-8]) << 31;
        return r;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // host and converter stimulus state
    bit h_wr, h_rd, inj, auto_conv;
    logic [3:0]  h_addr;
    logic [31:0] h_wdata, last_rd;
    logic [2:0]  inj_ch, pend_ch;
    logic [9:0]  inj_val;
    int pend = 0, vcount = 0, n_req = 0;
    int last_val[8];
    int req_q[$];

    task automatic step();
        @(negedge clk);
        check("rdata R2 R6 R11", reg_rdata, exp_rd(int'(reg_addr)));
        check("irq R7", 32'(irq), m_irq());
        check("conv_req R8 R9", 32'(conv_req), 32'(m_phase == 1));
        if (conv_req) begin
            check("req chan R9", 32'(conv_req_chan), 32'(m_cur));
            check("clocks R10", 32'(conv_clocks), (m_burst != 0) ? 32'(11 - m_acc) : 32'd11);
        end
        conv_done = 1'b0;
        if (inj) begin
            conv_done = 1'b1; conv_chan = inj_ch; conv_value = inj_val; inj = 0;
        end else if (pend == 1) begin
            vcount++;
            conv_done = 1'b1; conv_chan = pend_ch;
            conv_value = 10'((int'(pend_ch) * 101 + vcount * 37) & 1023);
            last_val[pend_ch] = int'(conv_value);
        end
        if (pend > 0) pend--;
        if (conv_req) begin
            n_req++; req_q.push_back(int'(conv_req_chan));
            if (auto_conv) begin pend = LAT; pend_ch = conv_req_chan; end
        end
        reg_wr = h_wr; reg_rd = h_rd; reg_addr = h_addr; reg_wdata = h_wdata;
        h_wr = 0; h_rd = 0;
        #1 last_rd = reg_rdata;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int a, logic [31:0] d);
        h_wr = 1; h_addr = 4'(a); h_wdata = d; step();
    endtask

    task automatic rd(int a, output logic [31:0] v);
        h_rd = 1; h_addr = 4'(a); step(); v = last_rd;
    endtask

    task automatic inject(int ch, int val);
        inj = 1; inj_ch = 3'(ch); inj_val = 10'(val); step();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(0, v);  check("R1 ctrl", v, 32'h0);
        rd(2, v);  check("R1 inten", v, 32'h100);
        rd(3, v);  check("R1 status", v, 32'h0);
        rd(1, v);  check("R1 global", v, 32'h0);
        rd(8, v);  check("R1 chan0", v, 32'h0);
        check("R1 irq", 32'(irq), 0);
        check("R1 conv_req", 32'(conv_req), 0);

        // R2 R3 R4 R6 R7 capture and clearing
        inject(3, 10'h2A5);
        rd(3, v);  check("R6 status", v, 32'h0001_0008);
        check("R7 irq global", 32'(irq), 1);
        rd(1, v);  check("R2 global", v, 32'h8300_A940);
        rd(1, v);  check("R3 read clears", v, 32'h0300_A940);
        check("R7 irq after clear", 32'(irq), 0);
        rd(11, v); check("R2 chan3", v, 32'h8000_A940);
        rd(11, v); check("R4 chan3 cleared", v, 32'h0000_A940);

        // R5 no overrun outside burst
        inject(5, 10'h001);
        inject(5, 10'h3FF);
        rd(13, v); check("R5 no ovr", v, 32'h8000_FFC0);

        // R7 per-channel enables, R4 selectivity
        wr(2, 32'h020);
        rd(2, v);  check("R7 inten", v, 32'h20);
        inject(5, 10'h010);
        idle(1);
        check("R7 chan irq", 32'(irq), 1);
        inject(2, 10'h100);
        rd(3, v);  check("R6 two done", v, 32'h0001_0024);
        rd(10, v);
        rd(3, v);  check("R4 other kept", v, 32'h0001_0020);
        rd(13, v);
        idle(1);
        check("R7 masked global", 32'(irq), 0);

        // R3 control write clears, capture wins over read
        inject(1, 10'h055);
        wr(0, 32'h0);
        rd(1, v);  check("R3 ctrl write clears", v, 32'h0100_1540);
        inj = 1; inj_ch = 3'd6; inj_val = 10'h0AA; h_rd = 1; h_addr = 4'd1; step();
        rd(1, v);  check("R3 capture wins", v, 32'h8600_2A80);

        // R11 readback, R8 other start codes ignored
        r0 = n_req;
        wr(0, 32'h4B0A_10A5);
        rd(0, v);  check("R11 ctrl readback", v, 32'h0B0A_00A5);
        idle(6);
        check("R8 code 3 ignored", 32'(n_req - r0), 0);

        // R8 software start, R10 full resolution
        auto_conv = 1;
        r0 = n_req; req_q.delete();
        wr(0, 32'h0100_0024);
        idle(12);
        check("R8 one request", 32'(n_req - r0), 1);
        if (req_q.size() > 0) check("R8 lowest chan", 32'(req_q[0]), 2);
        rd(0, v);  check("R8 start cleared", v, 32'h0000_0024);
        rd(10, v); check("R10 full width", v, 32'(last_val[2]) << 6 | 32'h8000_0000);

        // R9 burst ordering, R5 overrun, R10 reduced accuracy
        req_q.delete();
        wr(0, 32'h0005_0092);
        idle(45);
        if (req_q.size() >= 6) begin
            check("R9 order 0", 32'(req_q[0]), 1);
            check("R9 order 1", 32'(req_q[1]), 4);
            check("R9 order 2", 32'(req_q[2]), 7);
            check("R9 wrap", 32'(req_q[3]), 1);
            check("R9 order 4", 32'(req_q[4]), 4);
            check("R9 order 5", 32'(req_q[5]), 7);
        end else check("R9 request count", 32'(req_q.size()), 6);
        wr(0, 32'h0005_0000);
        idle(6);
        r0 = n_req;
        idle(10);
        check("R9 burst stopped", 32'(n_req - r0), 0);
        rd(9, v);  check("R5 R10 burst ovr", v, 32'(last_val[1] >> 2) << 6 | 32'hC000_0000);

        idle(2);
        summary();
        $finish;
    end

endmodule